// File: doc/BRIEF.md
# Current-Weighted Charge Safety Timer

This block bounds the length of a battery charge cycle. It counts ticks of a slow oscillator (nominally 75 µs per tick). At the default limit of 2^28 steps, that is roughly 5.6 hours when the full programmed current flows. The interval is a budget of charge, not of wall-clock time. On every tick the block adds the measured charge-current code to an accumulator. The elapsed count advances by one each time the accumulator holds a full programmed-current code. When power-path sharing, a source limit or thermal foldback lowers the real current, the count slows in proportion, so the charge delivered before expiry stays about the same.

Charge-control logic drives `clr_i` when constant-voltage charging begins, and when a recharge starts after a timeout. It drops `run_i` whenever charging is paused. It watches `timeout_o`. The meaning of an expiry is decided outside this block: an expiry after charge completion switches the charger off, and an expiry before completion is a fault. The count never runs faster than nominal, because a measured current above the programmed code is limited to the programmed code.

Top module: `chg_safety_timer`

## Requirements
- R1: With `run_i` high and the measured code at or above a nonzero programmed code, each `tick_i` advances `elapsed_o` by exactly one, visible the cycle after the tick edge.
- R2: From a cleared state, with a fixed nonzero programmed code P and no expiry, after ticks whose clamped codes min(meas,P) sum to Q, `elapsed_o` equals floor(Q/P).
- R3: `clr_i` sets `elapsed_o` and the internal accumulator to zero on the next edge and takes priority over a coincident tick.
- R4: A cycle with `tick_i` low or `run_i` low changes neither `elapsed_o` nor the accumulator.
- R5: `elapsed_o` never increases by more than one per clock, whatever the measured code.
- R6: When `elapsed_o` reaches LIMIT, `timeout_o` is high for exactly that one cycle. `elapsed_o` then holds at LIMIT, and no further pulse occurs until `clr_i`.
- R7: A programmed code of zero is treated as full rate: each active tick advances `elapsed_o` by one.
- R8: After reset, `elapsed_o` is zero and `timeout_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oscillator tick strobe, one clock wide |
| run_i | input | 1 | Charging active; timer holds when low |
| clr_i | input | 1 | Synchronous timer clear (CV entry, recharge start) |
| meas_i | input | CUR_W | Measured charge-current code |
| prog_i | input | CUR_W | Programmed charge-current code |
| timeout_o | output | 1 | One-cycle expiry pulse |
| elapsed_o | output | CNT_W | Elapsed weighted step count |

## Verification
The hardest situation to reach is the expiry boundary at a reduced rate. The remainder left in the accumulator decides the exact tick on which the final step lands, and the design must then ignore further ticks without pulsing again. The bench shrinks LIMIT so that segments with random fixed programmed codes and random measured codes below, above or around them reach expiry within a few hundred ticks. Gaps in tick and run are mixed in. A reference that divides the summed clamped charge by the programmed code predicts the pulse cycle. Directed steps add a clear on a tick cycle and a programmed code of zero.

// File: rtl/chg_tmr_pkg.sv
package chg_tmr_pkg;
  typedef enum logic {
    TMR_COUNTING = 1'b0,
    TMR_EXPIRED  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/chg_tmr_accum.sv
module chg_tmr_accum #(
  parameter int CUR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CUR_W-1:0] meas,
  input  logic [CUR_W-1:0] prog,
  output logic             step
);
  localparam int ACC_W = CUR_W + 1;

  // Current above the programmed code counts as the programmed code (R5).
  function automatic logic [ACC_W-1:0] clamp_rate(input logic [CUR_W-1:0] m,
                                                  input logic [CUR_W-1:0] p);
    return (m > p) ? ACC_W'(p) : ACC_W'(m);
  endfunction

  logic [ACC_W-1:0] acc_q, sum, acc_d;
  logic             full;

  always_comb begin
    sum  = acc_q + clamp_rate(meas, prog);
    full = (sum >= ACC_W'(prog));
    step = adv && full;
    acc_d = acc_q;
    if (clr)       acc_d = '0;
    else if (step) acc_d = sum - ACC_W'(prog);
    else if (adv)  acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R4: without an advance the accumulator holds
  a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(acc_q));
  // R3: clear empties the accumulator
  a_r3_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
endmodule

// File: rtl/chg_tmr_count.sv
module chg_tmr_count #(
  parameter int LIMIT = 1 << 28,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic             hit,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;

  assign hit   = step && (count_q == CNT_W'(LIMIT - 1));
  assign count = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (clr)  count_q <= '0;
    else if (step) count_q <= count_q + 1'b1;
  end

  // R5: at most one step per clock
  a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> ((count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)));
  // R3: clear zeroes the count
  a_r3_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == '0));
  // R6: count never passes the limit
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(LIMIT));
endmodule

// File: rtl/chg_tmr_expiry.sv
module chg_tmr_expiry
  import chg_tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  output logic expired,
  output logic pulse
);
  tmr_state_e st_q;
  logic       pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TMR_COUNTING;
      pulse_q <= 1'b0;
    end else if (clr) begin
      st_q    <= TMR_COUNTING;
      pulse_q <= 1'b0;
    end else if (hit && st_q == TMR_COUNTING) begin
      st_q    <= TMR_EXPIRED;
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign expired = (st_q == TMR_EXPIRED);
  assign pulse   = pulse_q;

  // R6: pulse lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R6: no second pulse while expired
  a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr) |=> !pulse_q);
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
  parameter int CUR_W = 10,
  parameter int LIMIT = 1 << 28,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CUR_W-1:0] meas_i,
  input  logic [CUR_W-1:0] prog_i,
  output logic             timeout_o,
  output logic [CNT_W-1:0] elapsed_o
);
  logic adv, step, hit, expired;

  assign adv = tick_i && run_i && !clr_i && !expired;

  chg_tmr_accum #(.CUR_W(CUR_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .adv(adv),
    .meas(meas_i), .prog(prog_i), .step(step)
  );

  chg_tmr_count #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .step(step),
    .hit(hit), .count(elapsed_o)
  );

  chg_tmr_expiry u_expiry (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .hit(hit),
    .expired(expired), .pulse(timeout_o)
  );

  // R4: idle cycles hold the count
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_i && run_i) && !clr_i) |=> $stable(elapsed_o));
  // R6: pulse coincides with the limit
  a_r6_pulse_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (elapsed_o == CNT_W'(LIMIT)));
  // R1: a full-rate tick always steps before expiry
  a_r1_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_i && !clr_i && !expired && meas_i >= prog_i)
      |=> (elapsed_o == $past(elapsed_o) + 1'b1));
endmodule

// File: tb/chg_safety_timer_test.sv
module chg_safety_timer_test;
  localparam int CUR_W = 8;
  localparam int LIMIT = 200;
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, run_i = 1'b0, clr_i = 1'b0;
  logic [CUR_W-1:0] meas_i = '0, prog_i = '0;
  logic timeout_o;
  logic [CNT_W-1:0] elapsed_o;

  int errors = 0, checks = 0;
  int q = 0, exp_el = 0;
  bit exp_pulse = 0;

  always #5 clk = ~clk;

  chg_safety_timer #(.CUR_W(CUR_W), .LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i), .clr_i(clr_i),
    .meas_i(meas_i), .prog_i(prog_i), .timeout_o(timeout_o), .elapsed_o(elapsed_o)
  );

  function automatic int weighted(input int m, input int p);
    return (m < p) ? m : p;
  endfunction

  function automatic int predict(input int charge, input int p);
    int v;
    v = charge / p;
    return (v > LIMIT) ? LIMIT : v;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cyc(input bit t, input bit r, input bit c, input int m, input string req);
    int prev;
    @(negedge clk);
    tick_i = t; run_i = r; clr_i = c; meas_i = CUR_W'(m);
    @(posedge clk);
    prev = exp_el;
    exp_pulse = 0;
    if (c) begin
      q = 0; exp_el = 0;
    end else if (t && r && exp_el < LIMIT) begin
      if (prog_i == 0) exp_el = exp_el + 1;
      else begin
        q = q + weighted(m, int'(prog_i));
        exp_el = predict(q, int'(prog_i));
      end
      if (prev < LIMIT && exp_el == LIMIT) exp_pulse = 1;
    end
    #1;
    check(req, int'(elapsed_o), exp_el);
    check("R6", int'(timeout_o), int'(exp_pulse));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check("R8", int'(elapsed_o), 0);
    check("R8", int'(timeout_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: full rate, one step per tick
    prog_i = 8'd100;
    cyc(1, 1, 1, 0, "R3");
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 100, "R1");
    // R5: far above programmed code still one step
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 255, "R5");
    // R3: clear wins over a coincident tick
    cyc(1, 1, 1, 255, "R3");
    // R2: quarter rate
    for (int i = 0; i < 8; i++) cyc(1, 1, 0, 25, "R2");
    // R4: run low, then tick low
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 100, "R4");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 100, "R4");
    // R7: programmed zero runs at full rate
    prog_i = 8'd0;
    cyc(0, 0, 1, 0, "R3");
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, "R7");
    // R6: expire at full rate and keep ticking
    prog_i = 8'd40;
    cyc(0, 0, 1, 0, "R3");
    for (int i = 0; i < LIMIT + 20; i++) cyc(1, 1, 0, 40, "R6");

    // random segments
    for (int s = 0; s < 24; s++) begin
      int mode;
      string tag;
      mode = s % 4;
      prog_i = (mode == 3) ? 8'd0 : CUR_W'(1 + ($urandom % 255));
      cyc(0, 0, 1, 0, "R3");
      tag = (mode == 0) ? "R2" : (mode == 1) ? "R5" : (mode == 2) ? "R4" : "R7";
      for (int i = 0; i < 700; i++) begin
        int m;
        bit t, r;
        case (mode)
          0: m = (prog_i > 1) ? int'($urandom % prog_i) : 0;
          1: m = int'(prog_i) + int'($urandom % (256 - int'(prog_i)));
          default: m = int'($urandom % 256);
        endcase
        t = ($urandom % 4) != 0;
        r = (mode == 2) ? (($urandom % 3) == 0) : (($urandom % 8) != 0);
        cyc(t, r, 0, m, tag);
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule